// File: doc/BRIEF.md
# UART Status and Interrupt Controller

This block is the register-side front end of a UART. It holds three control words, a status word and the received and transmitted data words. It collects receive and transmit events into status flags and merges those flags with per-source enable bits into one registered interrupt line. Received bytes arrive on a byte-wide valid/data interface. Each byte written for transmission leaves on a byte-wide one-cycle strobe.

Software uses a simple single-cycle 32-bit register bus. A read returns data in the same cycle, and any side effect of the read takes hold at the next clock edge. The line-level functions (idle detection, parity, framing, character match, end of block, receive timeout, auto-baud, clear-to-send change, break and wake-up) sit outside the block. An event input can set their status bits, and they take part in the interrupt merge like any other source.

Register offsets: control A 0x00, control B 0x04, control C 0x08, request 0x18, status 0x1C, clear 0x20, receive data 0x24, transmit data 0x28.

Status bits: 0 rx_full, 1 overrun, 2 tx_empty, 3 tx_done, 4 idle, 5 parity error, 6 framing error, 7 char match, 8 end of block, 9 rx timeout, 10 auto-baud, 11 cts change, 12 break, 13 wake, 16 tx ready ack.

Control A bits: 0 uart_en, 1 rx_en, 2 tx_empty_ie, 3 tx_done_ie, 4 rx_full_ie, 5 idle_ie, 6 parity_ie, 7 match_ie, 8 eob_ie, 9 rto_ie. Control B bits: 0 break_ie. Control C bits: 0 err_ie, 1 cts_ie, 2 wake_ie, 3 ovr_dis. Request bits: 0 rx flush.

Top module: `uart_status_irq`

## Requirements
- R1: A received byte is discarded, leaving status and receive data unchanged, unless control A has both uart_en (bit 0) and rx_en (bit 1) set.
- R2: When ovr_dis (control C bit 3) is clear and rx_full is set and not being cleared in that cycle, an accepted-interface byte sets overrun (status bit 1) and the receive data word keeps its old byte.
- R3: Any other enabled byte is written to the receive data word and sets rx_full. When a bus clear of rx_full falls in the same cycle as a byte, the byte wins: it is stored, rx_full stays set and overrun is not raised.
- R4: A read at 0x24 returns the stored byte in bits 7:0 with zeros above it, and clears rx_full at the next edge.
- R5: A write at 0x18 with bit 0 set clears rx_full.
- R6: A write at 0x20 clears each status bit whose written bit is 1. Writes at 0x1C and 0x24 change nothing.
- R7: A write at 0x28 stores the full word and sets tx_done (status bit 3). In the next cycle, tx_valid is high for exactly one cycle with the low byte on tx_data.
- R8: irq is high when any of these pairs has both bits set: tx_empty/tx_empty_ie, tx_done/tx_done_ie, rx_full/rx_full_ie, idle/idle_ie, parity/parity_ie, match/match_ie, eob/eob_ie, timeout/rto_ie, auto-baud/rx_full_ie, cts/cts_ie, break/break_ie, wake/wake_ie, framing/err_ie. It is also high when overrun is set with either rx_full_ie or err_ie.
- R9: After reset, status reads 0x0001000C, the other registers read 0 and irq is low.
- R10: rx_ready equals the inverse of rx_full in every cycle.
- R11: irq reflects the status and control state of the previous cycle (one register of latency).
- R12: evt_set sets only status bits 4 to 13, and set wins over a same-cycle clear.
- R13: When ovr_dis is set, a byte arriving while rx_full is set overwrites the receive data word and does not raise overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | BYTE_W | Received byte |
| rx_ready | output | 1 | Receive data word is free |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | BYTE_W | Transmit byte |
| evt_set | input | 32 | Sets status bits of external line functions |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that every bus request lasts one cycle, that a read has no effect until the following edge, and that rx_valid may be raised whether or not rx_ready is high. Under these assumptions, back-to-back bytes are a legal way to provoke an overrun. They also assume reset is applied before the first request. The stimulus changes inputs only on falling edges. It drives evt_set with all ones so that the mask on evt_set is exercised. It places a byte in the same cycle as a receive-data read, which covers the collision rule.

// File: rtl/uart_sic_pkg.sv
package uart_sic_pkg;
  localparam int REG_W = 32;

  localparam logic [7:0] OFF_CTRL_A = 8'h00;
  localparam logic [7:0] OFF_CTRL_B = 8'h04;
  localparam logic [7:0] OFF_CTRL_C = 8'h08;
  localparam logic [7:0] OFF_REQ    = 8'h18;
  localparam logic [7:0] OFF_STAT   = 8'h1C;
  localparam logic [7:0] OFF_CLR    = 8'h20;
  localparam logic [7:0] OFF_RXD    = 8'h24;
  localparam logic [7:0] OFF_TXD    = 8'h28;

  // status bit positions
  localparam int S_RXF   = 0;
  localparam int S_OVR   = 1;
  localparam int S_TXE   = 2;
  localparam int S_TXD   = 3;
  localparam int S_IDLE  = 4;
  localparam int S_PAR   = 5;
  localparam int S_FRM   = 6;
  localparam int S_MATCH = 7;
  localparam int S_EOB   = 8;
  localparam int S_RTO   = 9;
  localparam int S_ABR   = 10;
  localparam int S_CTS   = 11;
  localparam int S_BRK   = 12;
  localparam int S_WAKE  = 13;
  localparam int S_TACK  = 16;

  // control A
  localparam int A_UEN   = 0;
  localparam int A_RXEN  = 1;
  localparam int A_TXEIE = 2;
  localparam int A_TXDIE = 3;
  localparam int A_RXFIE = 4;
  localparam int A_IDLIE = 5;
  localparam int A_PARIE = 6;
  localparam int A_MATIE = 7;
  localparam int A_EOBIE = 8;
  localparam int A_RTOIE = 9;
  // control B
  localparam int B_BRKIE = 0;
  // control C
  localparam int C_ERRIE = 0;
  localparam int C_CTSIE = 1;
  localparam int C_WAKIE = 2;
  localparam int C_OVDIS = 3;
  // request
  localparam int Q_FLUSH = 0;

  localparam logic [REG_W-1:0] STAT_RST =
    (REG_W'(1) << S_TXE) | (REG_W'(1) << S_TXD) | (REG_W'(1) << S_TACK);
  localparam logic [REG_W-1:0] EVT_MASK = REG_W'(32'h0000_3FF0);
  localparam logic [REG_W-1:0] RX_OWNED = (REG_W'(1) << S_RXF) | (REG_W'(1) << S_OVR);

  typedef struct packed {
    logic sel;
    logic we;
    logic [7:0] off;
    logic [REG_W-1:0] wdata;
  } bus_req_t;

  function automatic logic irq_merge(input logic [REG_W-1:0] st,
                                     input logic [REG_W-1:0] ca,
                                     input logic [REG_W-1:0] cb,
                                     input logic [REG_W-1:0] cc);
    logic [13:0] src;
    src[0]  = st[S_TXE]   & ca[A_TXEIE];
    src[1]  = st[S_TXD]   & ca[A_TXDIE];
    src[2]  = st[S_RXF]   & ca[A_RXFIE];
    src[3]  = st[S_IDLE]  & ca[A_IDLIE];
    src[4]  = st[S_PAR]   & ca[A_PARIE];
    src[5]  = st[S_MATCH] & ca[A_MATIE];
    src[6]  = st[S_EOB]   & ca[A_EOBIE];
    src[7]  = st[S_RTO]   & ca[A_RTOIE];
    src[8]  = st[S_ABR]   & ca[A_RXFIE];
    src[9]  = st[S_CTS]   & cc[C_CTSIE];
    src[10] = st[S_BRK]   & cb[B_BRKIE];
    src[11] = st[S_WAKE]  & cc[C_WAKIE];
    src[12] = st[S_FRM]   & cc[C_ERRIE];
    src[13] = st[S_OVR]   & (ca[A_RXFIE] | cc[C_ERRIE]);
    return |src;
  endfunction

  function automatic logic off_hit(input bus_req_t r, input logic [7:0] off, input logic wr);
    return r.sel && (r.we == wr) && (r.off == off);
  endfunction
endpackage

// File: rtl/uart_sic_rx.sv
module uart_sic_rx #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  input  logic              rx_enabled,
  input  logic              ovr_det_en,
  input  logic              clr_full,
  input  logic              clr_ovr,
  output logic              full_q,
  output logic              ovr_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              accept_evt,
  output logic              ovr_evt
);
  logic take;

  assign take       = in_valid & rx_enabled;
  assign ovr_evt    = take & ovr_det_en & full_q & ~clr_full;
  assign accept_evt = take & ~ovr_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (accept_evt) begin
      full_q <= 1'b1;
      data_q <= in_byte;
    end else if (clr_full) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (ovr_evt) ovr_q <= 1'b1;
    else if (clr_ovr) ovr_q <= 1'b0;
  end

  // R1: a dropped byte leaves the data word untouched
  assert_drop_keeps_data_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !rx_enabled) |=> $stable(data_q));

  // R2: overrun keeps the old byte and raises the flag
  assert_overrun_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> (ovr_q && $stable(data_q)));

  // R3: accepted byte lands in the data word with rx_full set
  assert_accept_stores_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (full_q && data_q == $past(in_byte)));

  // R5: a clear with no incoming byte empties the holding word
  assert_clear_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_full && !accept_evt) |=> !full_q);
endmodule

// File: rtl/uart_sic_tx.sv
module uart_sic_tx #(
  parameter int BYTE_W = 8,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  word_q,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      tx_valid <= wr;
      if (wr) begin
        word_q  <= wdata;
        tx_data <= wdata[BYTE_W-1:0];
      end
    end
  end

  // R7: each write yields one strobe carrying its low byte
  assert_tx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (tx_valid && tx_data == $past(wdata[BYTE_W-1:0])));
  assert_tx_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> !tx_valid);
endmodule

// File: rtl/uart_sic_irq.sv
module uart_sic_irq
  import uart_sic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] stat,
  input  logic [REG_W-1:0] ctrl_a,
  input  logic [REG_W-1:0] ctrl_b,
  input  logic [REG_W-1:0] ctrl_c,
  output logic             irq_q
);
  logic irq_comb;

  assign irq_comb = irq_merge(stat, ctrl_a, ctrl_b, ctrl_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_comb;
  end

  // R8: overrun raises the line through the error enable alone
  assert_ovr_err_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[S_OVR] && ctrl_c[C_ERRIE]) |=> irq_q);
  // R8: auto-baud flag shares the rx_full enable
  assert_abr_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[S_ABR] && ctrl_a[A_RXFIE]) |=> irq_q);
endmodule

// File: rtl/uart_status_irq.sv
module uart_status_irq
  import uart_sic_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  input  logic [31:0]       evt_set,
  output logic              irq
);
  bus_req_t req;
  logic [REG_W-1:0] ctrl_a_q, ctrl_b_q, ctrl_c_q, stat_q, stat_nxt, stat_view;
  logic [REG_W-1:0] tx_word;
  logic [BYTE_W-1:0] rx_byte;
  logic rx_full, rx_ovr, accept_evt, ovr_evt;
  logic rd_rx_evt, flush_evt, clr_wr, tx_wr, clr_full, clr_ovr, rx_enabled;
  logic ie_none;

  assign req.sel   = bus_sel;
  assign req.we    = bus_we;
  assign req.off   = 8'(bus_addr);
  assign req.wdata = bus_wdata;

  assign rd_rx_evt = off_hit(req, OFF_RXD, 1'b0);
  assign flush_evt = off_hit(req, OFF_REQ, 1'b1) && bus_wdata[Q_FLUSH];
  assign clr_wr    = off_hit(req, OFF_CLR, 1'b1);
  assign tx_wr     = off_hit(req, OFF_TXD, 1'b1);
  assign clr_full  = rd_rx_evt | flush_evt | (clr_wr & bus_wdata[S_RXF]);
  assign clr_ovr   = clr_wr & bus_wdata[S_OVR];
  assign rx_enabled = ctrl_a_q[A_UEN] & ctrl_a_q[A_RXEN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_a_q <= '0;
      ctrl_b_q <= '0;
      ctrl_c_q <= '0;
    end else begin
      if (off_hit(req, OFF_CTRL_A, 1'b1)) ctrl_a_q <= bus_wdata;
      if (off_hit(req, OFF_CTRL_B, 1'b1)) ctrl_b_q <= bus_wdata;
      if (off_hit(req, OFF_CTRL_C, 1'b1)) ctrl_c_q <= bus_wdata;
    end
  end

  uart_sic_rx #(.BYTE_W(BYTE_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (rx_valid),
    .in_byte    (rx_data),
    .rx_enabled (rx_enabled),
    .ovr_det_en (~ctrl_c_q[C_OVDIS]),
    .clr_full   (clr_full),
    .clr_ovr    (clr_ovr),
    .full_q     (rx_full),
    .ovr_q      (rx_ovr),
    .data_q     (rx_byte),
    .accept_evt (accept_evt),
    .ovr_evt    (ovr_evt)
  );

  uart_sic_tx #(.BYTE_W(BYTE_W), .REG_W(REG_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (tx_wr),
    .wdata    (bus_wdata),
    .word_q   (tx_word),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  // other status bits: clear first, then sets override
  always_comb begin
    stat_nxt = stat_q;
    if (clr_wr) stat_nxt = stat_nxt & ~bus_wdata;
    stat_nxt = stat_nxt | (evt_set & EVT_MASK);
    if (tx_wr) stat_nxt[S_TXD] = 1'b1;
    stat_nxt = stat_nxt & ~RX_OWNED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= STAT_RST & ~RX_OWNED;
    else        stat_q <= stat_nxt;
  end

  assign stat_view = stat_q | (REG_W'(rx_full) << S_RXF) | (REG_W'(rx_ovr) << S_OVR);
  assign rx_ready  = ~rx_full;

  uart_sic_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .stat   (stat_view),
    .ctrl_a (ctrl_a_q),
    .ctrl_b (ctrl_b_q),
    .ctrl_c (ctrl_c_q),
    .irq_q  (irq)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_we) begin
      unique case (req.off)
        OFF_CTRL_A: bus_rdata = ctrl_a_q;
        OFF_CTRL_B: bus_rdata = ctrl_b_q;
        OFF_CTRL_C: bus_rdata = ctrl_c_q;
        OFF_STAT:   bus_rdata = stat_view;
        OFF_RXD:    bus_rdata = REG_W'(rx_byte);
        OFF_TXD:    bus_rdata = tx_word;
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign ie_none = (ctrl_a_q[A_RTOIE:A_TXEIE] == '0) && !ctrl_b_q[B_BRKIE] &&
                   (ctrl_c_q[C_WAKIE:C_ERRIE] == '0);

  // R8: with every enable clear, the line stays low
  assert_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ie_none |=> !irq);
  // R6: status written directly keeps its value apart from event sets
  assert_stat_write_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (off_hit(req, OFF_STAT, 1'b1) && evt_set == '0 && !rx_valid) |=> $stable(stat_view));
  // R12: event input never touches rx-side flags
  assert_evt_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !rx_full) |=> !rx_full);
endmodule

// File: tb/uart_status_irq_tb.sv
module uart_status_irq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic rx_ready, tx_valid, irq;
  logic [7:0] tx_data;
  logic [31:0] evt_set = '0;

  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  uart_status_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .evt_set(evt_set), .irq(irq)
  );

  // reference model state
  logic [31:0] m_st, m_ca, m_cb, m_cc, m_tdr;
  logic [7:0] m_rdr, m_txd;
  bit m_irq, m_txv;

  function automatic bit ref_irq(logic [31:0] s, logic [31:0] a, logic [31:0] b, logic [31:0] c);
    bit r = 0;
    r |= s[2] & a[2];   r |= s[3] & a[3];   r |= s[0] & a[4];
    r |= s[10] & a[4];  r |= s[4] & a[5];   r |= s[5] & a[6];
    r |= s[7] & a[7];   r |= s[8] & a[8];   r |= s[9] & a[9];
    r |= s[11] & c[1];  r |= s[12] & b[0];  r |= s[13] & c[2];
    r |= s[6] & c[0];   r |= s[1] & (a[4] | c[0]);
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 32'h0001_000C; m_ca = 0; m_cb = 0; m_cc = 0; m_tdr = 0;
      m_rdr = 0; m_txd = 0; m_irq = 0; m_txv = 0;
    end else begin
      logic [31:0] ns;
      bit w, r, rxclr;
      w = bus_sel & bus_we;
      r = bus_sel & ~bus_we;
      m_irq = ref_irq(m_st, m_ca, m_cb, m_cc);
      rxclr = (r && bus_addr == 8'h24) || (w && bus_addr == 8'h18 && bus_wdata[0]) ||
              (w && bus_addr == 8'h20 && bus_wdata[0]);
      ns = m_st;
      if (w && bus_addr == 8'h20) ns &= ~bus_wdata;
      if (rxclr) ns[0] = 0;
      ns |= evt_set & 32'h0000_3FF0;
      m_txv = w && bus_addr == 8'h28;
      if (m_txv) begin m_txd = bus_wdata[7:0]; m_tdr = bus_wdata; ns[3] = 1; end
      if (rx_valid && m_ca[0] && m_ca[1]) begin
        if (!m_cc[3] && m_st[0] && !rxclr) ns[1] = 1;
        else begin m_rdr = rx_data; ns[0] = 1; end
      end
      if (w && bus_addr == 8'h00) m_ca = bus_wdata;
      if (w && bus_addr == 8'h04) m_cb = bus_wdata;
      if (w && bus_addr == 8'h08) m_cc = bus_wdata;
      m_st = ns;
    end
  end

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison with the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(irq === m_irq, "R8/R11 irq", 32'(irq), 32'(m_irq));
      chk(rx_ready === !m_st[0], "R10 rx_ready", 32'(rx_ready), 32'(!m_st[0]));
      chk(tx_valid === m_txv, "R7 tx_valid", 32'(tx_valid), 32'(m_txv));
      if (m_txv) chk(tx_data === m_txd, "R7 tx_data", 32'(tx_data), 32'(m_txd));
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk); bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 chk(bus_rdata === exp, tag, bus_rdata, exp);
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_data = b;
    @(negedge clk); rx_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    rd(8'h1C, 32'h0001_000C, "R9 status reset");
    rd(8'h24, 0, "R9 rx data reset");
    rd(8'h28, 0, "R9 tx data reset");
    rd(8'h00, 0, "R9 control A reset");
    chk(irq === 0, "R9 irq reset", 32'(irq), 0);

    // R1 drops while disabled
    send(8'h11);
    rd(8'h1C, 32'h0001_000C, "R1 status after drop");
    wr(8'h00, 32'h2);
    send(8'h12);
    rd(8'h24, 0, "R1 rx data after drop");

    // R3 / R4 normal receive
    wr(8'h00, 32'h3);
    send(8'h5A);
    rd(8'h1C, 32'h0001_000D, "R3 rx_full set");
    rd(8'h24, 32'h5A, "R4 read byte");
    rd(8'h1C, 32'h0001_000C, "R4 rx_full cleared by read");

    // R2 overrun
    send(8'hA1);
    send(8'hB2);
    rd(8'h1C, 32'h0001_000F, "R2 overrun set");
    rd(8'h24, 32'hA1, "R2 old byte kept");
    wr(8'h20, 32'h2);
    rd(8'h1C, 32'h0001_000C, "R6 overrun cleared");

    // R13 overrun detection off
    wr(8'h08, 32'h8);
    send(8'h10);
    send(8'h20);
    rd(8'h1C, 32'h0001_000D, "R13 no overrun");
    rd(8'h24, 32'h20, "R13 newest byte kept");
    wr(8'h08, 32'h0);

    // R5 flush
    send(8'h44);
    rd(8'h1C, 32'h0001_000D, "R5 full before flush");
    wr(8'h18, 32'h1);
    rd(8'h1C, 32'h0001_000C, "R5 flush clears rx_full");

    // R3 collision of a read with a new byte
    send(8'h55);
    @(negedge clk); rx_valid = 1; rx_data = 8'h33; bus_sel = 1; bus_we = 0; bus_addr = 8'h24;
    #1 chk(bus_rdata === 32'h55, "R4 read during collision", bus_rdata, 32'h55);
    @(negedge clk); rx_valid = 0; bus_sel = 0;
    rd(8'h1C, 32'h0001_000D, "R3 collision keeps rx_full, no overrun");
    rd(8'h24, 32'h33, "R3 collision byte stored");

    // R6 ignored writes and clear
    wr(8'h1C, 32'hFFFF_FFFF);
    rd(8'h1C, 32'h0001_000C, "R6 status write ignored");
    wr(8'h24, 32'h77);
    rd(8'h24, 32'h33, "R6 rx data write ignored");
    wr(8'h20, 32'h0001_000C);
    rd(8'h1C, 32'h0, "R6 clear register");

    // R7 transmit
    @(negedge clk); bus_sel = 1; bus_we = 1; bus_addr = 8'h28; bus_wdata = 32'h1234_56C3;
    @(negedge clk); bus_sel = 0; bus_we = 0;
    chk(tx_valid === 1 && tx_data === 8'hC3, "R7 strobe with low byte", {23'd0, tx_valid, tx_data}, 32'h1C3);
    @(negedge clk);
    chk(tx_valid === 0, "R7 single-cycle strobe", 32'(tx_valid), 0);
    rd(8'h1C, 32'h8, "R7 tx_done set");
    rd(8'h28, 32'h1234_56C3, "R7 word stored");

    // R12 event mask
    @(negedge clk); evt_set = 32'hFFFF_FFFF;
    @(negedge clk); evt_set = 0;
    rd(8'h1C, 32'h0000_3FF8, "R12 only external bits set");
    chk(rx_ready === 1, "R12 rx_ready untouched", 32'(rx_ready), 1);

    // R8 / R11 pairings one enable at a time
    for (int i = 2; i <= 9; i++) begin
      wr(8'h00, 32'h3 | (32'h1 << i));
      @(negedge clk);
      chk(irq === ref_irq(m_st, m_ca, m_cb, m_cc), "R8 control A pair", 32'(irq), 32'(ref_irq(m_st, m_ca, m_cb, m_cc)));
    end
    wr(8'h00, 32'h3);
    for (int i = 0; i <= 2; i++) begin
      wr(8'h08, 32'h1 << i);
      @(negedge clk);
      chk(irq === 1, "R8 control C pair", 32'(irq), 1);
    end
    wr(8'h08, 0);
    wr(8'h04, 32'h1);
    @(negedge clk);
    chk(irq === 1, "R8 break pair", 32'(irq), 1);
    wr(8'h04, 0);
    @(negedge clk);
    chk(irq === 0, "R11 irq drops after enables clear", 32'(irq), 0);

    // R8 overrun on either enable
    wr(8'h20, 32'hFFFF_FFFF);
    send(8'h01);
    send(8'h02);
    wr(8'h18, 32'h1);
    rd(8'h1C, 32'h2, "R2 overrun alone");
    wr(8'h00, 32'h13);
    @(negedge clk);
    chk(irq === 1, "R8 overrun via rx_full_ie", 32'(irq), 1);
    wr(8'h00, 32'h3);
    wr(8'h08, 32'h1);
    @(negedge clk);
    chk(irq === 1, "R8 overrun via err_ie", 32'(irq), 1);
    wr(8'h08, 32'h0);
    @(negedge clk);
    chk(irq === 0, "R8 overrun with no enable", 32'(irq), 0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule